// File: doc/BRIEF.md
# Pipelined No-Wait-State Synchronous SRAM

This block is a synthesizable model of a pipelined synchronous static RAM. Its data bus is split into an input word, an output word and an output-valid flag. Every command is registered on the rising clock edge and then travels down a two-stage pipeline. Write data enters at the same pipeline depth at which read data leaves. Because of this, any mix of reads and writes, strictly alternating ones included, runs every cycle with no turnaround gap. The storage is 256 words of two 9-bit bytes. Each byte has its own active-low write enable.

A controller starts a command by loading an address with the advance/load input low. It then steps through a four-beat burst by holding that input high. The burst order is linear or interleaved, chosen by a mode pin. Three chip enables of mixed polarity qualify each load. A load that is not selected becomes a bubble that makes no array access. An active-low clock enable freezes the whole block when it is high: pipeline, burst state, outputs and storage.

Top module: `nws_sram`

## Requirements
- R1: A read command registered at enabled edge E puts the stored word on dout_o, with oe_o high, right after the enabled edge E+2. Both hold until the next enabled edge.
- R2: While cke_ni is high, every other input is ignored. The pipeline, burst state, oe_o, dout_o and the storage all keep their values, and a suspended command resumes when cke_ni returns low.
- R3: A write is started by a selected load with we_ni low. Its data is taken from din_i at the second enabled edge after the command edge.
- R4: bw_ni[0] enables bits 8:0 and bw_ni[1] enables bits 17:9. Each is active low, and a byte whose enable is high keeps its stored contents.
- R5: adv_ld_i low loads addr_i and a new command. adv_ld_i high continues the current burst with the same command kind at the next burst address. On an advance, we_ni and the chip enables are ignored, while bw_ni is taken per beat.
- R6: A load is selected only when ce_ni is low, ce2_i is high and ce3_ni is low. Any other combination makes the load a deselect.
- R7: Reads and writes may alternate on consecutive cycles with no idle cycle. A read issued in the cycle right after a write to the same address returns the newly written data.
- R8: oe_o is high only in the cycle where read data is valid. It stays low after writes, deselects and bubbles, and dout_o then keeps its last value.
- R9: A deselected load makes no array access, even with we_ni low and both byte enables active.
- R10: Burst address bits 1:0 for beat n (n = 0..3, wrapping) are (base+n) mod 4 when mode_i is 0, and base XOR n when mode_i is 1. Bits 7:2 stay at the loaded value.
- R11: After reset, oe_o is low, dout_o is zero, the pipeline holds no command, and an advance with no prior load acts as a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low; high suspends the block |
| adv_ld_i | input | 1 | 0 = load a new command, 1 = advance the burst |
| we_ni | input | 1 | 0 = write, 1 = read, sampled at load |
| ce_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| bw_ni | input | 2 | Byte write enables, active low, one per 9-bit byte |
| mode_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr_i | input | 8 | Word address |
| din_i | input | 18 | Write data, sampled two enabled edges after the command |
| dout_o | output | 18 | Read data |
| oe_o | output | 1 | High while dout_o carries valid read data |

## Verification
In a single cycle, a write can commit its data to the array while a read that entered one cycle later leaves the second stage. The read then reads the array right after the write edge. The bench provokes this by issuing a write followed at once by a read of the same address, in strictly alternating sequences. It judges the result against a bench-side memory model updated at the data edge. A second collision, a clock suspension arriving while both stages hold commands, is judged by checking that outputs freeze and that the pending write later takes the data present at the resumed edge.

// File: rtl/nws_pkg.sv
package nws_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_RD, OP_WR} op_e;

  function automatic logic [1:0] burst_low(input logic [1:0] base, input logic [1:0] cnt,
                                           input logic ilv);
    return ilv ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/nws_burst.sv
module nws_burst
  import nws_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          load_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          ilv_i,
  input  logic [AW-1:0] addr_i,
  output op_e           op_o,
  output logic [AW-1:0] addr_o
);
  localparam int unsigned CW = 2;

  logic [AW-1:0] base_q;
  logic [CW-1:0] cnt_q, cnt_nx;
  op_e           kind_q;

  assign cnt_nx = cnt_q + 1'b1;

  always_comb begin
    if (load_i) begin
      op_o   = sel_i ? (wr_i ? OP_WR : OP_RD) : OP_NONE;
      addr_o = addr_i;
    end else begin
      op_o   = kind_q;
      addr_o = {base_q[AW-1:CW], burst_low(base_q[CW-1:0], cnt_nx, ilv_i)};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      cnt_q  <= '0;
      kind_q <= OP_NONE;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        cnt_q  <= '0;
        kind_q <= op_o;
      end else begin
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/nws_array.sv
module nws_array #(
  parameter int unsigned AW  = 8,
  parameter int unsigned NB  = 2,
  parameter int unsigned BYW = 9
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [NB*BYW-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [NB*BYW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYW-1:0] mem [DEPTH];

    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[waddr_i] <= wdata_i[g*BYW +: BYW];
    end

    assign rdata_o[g*BYW +: BYW] = mem[raddr_i];
  end
endmodule

// File: rtl/nws_sram.sv
module nws_sram
  import nws_pkg::*;
#(
  parameter int unsigned AW  = 8,
  parameter int unsigned NB  = 2,
  parameter int unsigned BYW = 9,
  localparam int unsigned DW = NB * BYW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cke_ni,
  input  logic          adv_ld_i,
  input  logic          we_ni,
  input  logic          ce_ni,
  input  logic          ce2_i,
  input  logic          ce3_ni,
  input  logic [NB-1:0] bw_ni,
  input  logic          mode_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o,
  output logic          oe_o
);
  logic          en, sel;
  op_e           op_c;
  logic [AW-1:0] addr_c;

  op_e           s1_op_q, s2_op_q;
  logic [AW-1:0] s1_addr_q, s2_addr_q;
  logic [NB-1:0] s1_be_q, s2_be_q;
  logic [DW-1:0] rdata;
  logic [DW-1:0] dout_q;
  logic          oe_q;

  assign en  = !cke_ni;
  assign sel = !ce_ni && ce2_i && !ce3_ni;

  nws_burst #(.AW(AW)) i_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .load_i (!adv_ld_i),
    .sel_i  (sel),
    .wr_i   (!we_ni),
    .ilv_i  (mode_i),
    .addr_i (addr_i),
    .op_o   (op_c),
    .addr_o (addr_c)
  );

  // two command stages; write data meets stage 2 at the same depth read data leaves
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_op_q   <= OP_NONE;
      s1_addr_q <= '0;
      s1_be_q   <= '0;
      s2_op_q   <= OP_NONE;
      s2_addr_q <= '0;
      s2_be_q   <= '0;
    end else if (en) begin
      s1_op_q   <= op_c;
      s1_addr_q <= addr_c;
      s1_be_q   <= ~bw_ni;
      s2_op_q   <= s1_op_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
    end
  end

  nws_array #(.AW(AW), .NB(NB), .BYW(BYW)) i_array (
    .clk_i   (clk_i),
    .we_i    (en && (s2_op_q == OP_WR)),
    .be_i    (s2_be_q),
    .waddr_i (s2_addr_q),
    .wdata_i (din_i),
    .raddr_i (s2_addr_q),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_q   <= 1'b0;
      dout_q <= '0;
    end else if (en) begin
      oe_q <= (s2_op_q == OP_RD);
      if (s2_op_q == OP_RD) dout_q <= rdata;
    end
  end

  assign oe_o   = oe_q;
  assign dout_o = dout_q;
endmodule

// File: rtl/nws_sram_chk.sv
module nws_sram_chk
  import nws_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cke_ni,
  input logic          adv_ld_i,
  input logic          ce_ni,
  input logic          ce2_i,
  input logic          ce3_ni,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] dout_o,
  input logic          oe_o,
  input op_e           s1_op_i,
  input op_e           s2_op_i,
  input logic [AW-1:0] s1_addr_i
);
  // R2
  suspend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(dout_o) && $stable(oe_o) && $stable(s1_op_i) && $stable(s2_op_i)));

  // R8
  oe_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s2_op_i == OP_RD) |=> oe_o);

  // R8
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s2_op_i != OP_RD) |=> !oe_o);

  // R6
  deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i && !(!ce_ni && ce2_i && !ce3_ni)) |=> (s1_op_i == OP_NONE));

  // R5
  load_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_ld_i) |=> (s1_addr_i == $past(addr_i)));

  // R1
  stage_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_ni |=> (s2_op_i == $past(s1_op_i)));
endmodule

bind nws_sram nws_sram_chk #(.AW(AW), .DW(DW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cke_ni    (cke_ni),
  .adv_ld_i  (adv_ld_i),
  .ce_ni     (ce_ni),
  .ce2_i     (ce2_i),
  .ce3_ni    (ce3_ni),
  .addr_i    (addr_i),
  .dout_o    (dout_o),
  .oe_o      (oe_o),
  .s1_op_i   (s1_op_q),
  .s2_op_i   (s2_op_q),
  .s1_addr_i (s1_addr_q)
);

// File: tb/test_nws_sram.sv
module test_nws_sram;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cke_ni = 1'b0;
  logic        adv_ld_i = 1'b0;
  logic        we_ni = 1'b1;
  logic        ce_ni = 1'b1;
  logic        ce2_i = 1'b0;
  logic        ce3_ni = 1'b1;
  logic [1:0]  bw_ni = 2'b11;
  logic        mode_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [17:0] din_i = '0;
  logic [17:0] dout_o;
  logic        oe_o;

  always #10 clk_i = ~clk_i;

  nws_sram i_nws_sram (
    .clk_i, .rst_ni, .cke_ni, .adv_ld_i, .we_ni, .ce_ni, .ce2_i, .ce3_ni,
    .bw_ni, .mode_i, .addr_i, .din_i, .dout_o, .oe_o
  );

  typedef struct packed {
    logic        v;
    logic        w;
    logic [7:0]  a;
    logic [1:0]  be;
    logic [17:0] d;
  } cmd_t;

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  cmd_t        q0 = '0, q1 = '0;
  logic [7:0]  bb = '0;
  logic [1:0]  bc = '0;
  int          bk = 0;
  logic        exp_oe = 1'b0;
  logic [17:0] exp_d = '0;
  logic [17:0] mm [256];

  task automatic chk(input string tag, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  // one clock: drive pins, update the bench model at the edge, check at the falling edge
  task automatic step(input logic ck_n, input logic adv, input logic [2:0] ce, input logic we_n,
                      input logic [7:0] a, input logic [1:0] bw, input logic [17:0] wd,
                      input logic md, input string tag);
    cmd_t c;
    logic [1:0] lo;
    cke_ni = ck_n; adv_ld_i = adv; {ce_ni, ce2_i, ce3_ni} = ce; we_ni = we_n;
    addr_i = a; bw_ni = bw; mode_i = md; din_i = q1.d;
    @(posedge clk_i);
    if (!ck_n) begin
      c.d  = wd;
      c.be = ~bw;
      if (!adv) begin
        bk = (ce == 3'b010) ? (we_n ? 1 : 2) : 0;
        bb = a; bc = '0; c.a = a;
      end else begin
        bc = bc + 2'd1;
        lo = md ? (bb[1:0] ^ bc) : (bb[1:0] + bc);
        c.a = {bb[7:2], lo};
      end
      c.v = (bk != 0);
      c.w = (bk == 2);
      if (q1.v && q1.w) begin
        if (q1.be[0]) mm[q1.a][8:0]  = q1.d[8:0];
        if (q1.be[1]) mm[q1.a][17:9] = q1.d[17:9];
      end
      exp_oe = q1.v && !q1.w;
      if (exp_oe) exp_d = mm[q1.a];
      q1 = q0;
      q0 = c;
    end
    @(negedge clk_i);
    chk({tag, " oe (R8)"}, {17'd0, oe_o}, {17'd0, exp_oe});
    chk({tag, " data"}, dout_o, exp_d);
  endtask

  task automatic wr(input logic [7:0] a, input logic [17:0] d, input logic [1:0] bw, input string tag);
    step(1'b0, 1'b0, 3'b010, 1'b0, a, bw, d, 1'b0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    step(1'b0, 1'b0, 3'b010, 1'b1, a, 2'b11, 18'h0, 1'b0, tag);
  endtask
  task automatic nop(input string tag);
    step(1'b0, 1'b0, 3'b100, 1'b1, 8'h00, 2'b11, 18'h0, 1'b0, tag);
  endtask
  task automatic adv(input logic we_n, input logic [1:0] bw, input logic [17:0] d, input logic md,
                     input string tag);
    step(1'b0, 1'b1, 3'b101, we_n, 8'hff, bw, d, md, tag);
  endtask
  task automatic stall(input string tag);
    step(1'b1, 1'b0, 3'b010, 1'b0, 8'h70, 2'b00, 18'h3ffff, 1'b1, tag);
  endtask

  task automatic t_reset;
    chk("R11 reset oe", {17'd0, oe_o}, 18'd0);
    chk("R11 reset dout", dout_o, 18'd0);
    step(1'b0, 1'b1, 3'b010, 1'b0, 8'h10, 2'b00, 18'h1234, 1'b0, "R11 orphan advance");
    nop("R11"); nop("R11");
  endtask

  task automatic t_basic;
    wr(8'h20, 18'h0a5a5, 2'b00, "R3"); wr(8'h21, 18'h35a5a, 2'b00, "R3");
    wr(8'h22, 18'h00001, 2'b00, "R3"); wr(8'h23, 18'h3fffe, 2'b00, "R3");
    nop("R1"); nop("R1");
    rd(8'h23, "R1"); rd(8'h20, "R1"); rd(8'h22, "R1"); rd(8'h21, "R1");
    nop("R1"); nop("R1");
  endtask

  task automatic t_bytes;
    wr(8'h30, 18'h3ffff, 2'b00, "R4");
    wr(8'h30, 18'h00000, 2'b10, "R4 low byte");
    rd(8'h30, "R4");
    wr(8'h30, 18'h00000, 2'b01, "R4 high byte");
    wr(8'h30, 18'h12345, 2'b11, "R4 none");
    rd(8'h30, "R4");
    nop("R4"); nop("R4");
  endtask

  task automatic t_alt;
    wr(8'h40, 18'h11111, 2'b00, "R7"); rd(8'h40, "R7");
    wr(8'h41, 18'h22222, 2'b00, "R7"); rd(8'h41, "R7");
    rd(8'h40, "R7"); wr(8'h40, 18'h33333, 2'b00, "R7");
    rd(8'h40, "R7"); wr(8'h41, 18'h04444, 2'b00, "R7");
    rd(8'h41, "R7");
    nop("R7"); nop("R7");
  endtask

  task automatic t_sel;
    wr(8'h50, 18'h00111, 2'b00, "R6");
    step(1'b0, 1'b0, 3'b110, 1'b0, 8'h50, 2'b00, 18'h0, 1'b0, "R6 ce_ni high");
    step(1'b0, 1'b0, 3'b000, 1'b0, 8'h50, 2'b00, 18'h0, 1'b0, "R6 ce2_i low");
    step(1'b0, 1'b0, 3'b011, 1'b0, 8'h50, 2'b00, 18'h0, 1'b0, "R6 ce3_ni high");
    rd(8'h50, "R6");
    nop("R6"); nop("R6");
  endtask

  task automatic t_desel;
    wr(8'h58, 18'h00abc, 2'b00, "R9");
    rd(8'h58, "R9");
    step(1'b0, 1'b0, 3'b100, 1'b0, 8'h58, 2'b00, 18'h3ffff, 1'b0, "R9 bubble");
    nop("R9");
    rd(8'h58, "R9");
    nop("R9"); nop("R9");
  endtask

  task automatic t_burst;
    step(1'b0, 1'b0, 3'b010, 1'b0, 8'h62, 2'b00, 18'h00aaa, 1'b0, "R10 linear load");
    adv(1'b1, 2'b00, 18'h00bbb, 1'b0, "R5 we ignored");
    adv(1'b1, 2'b10, 18'h3fccc, 1'b0, "R5 per-beat bw");
    adv(1'b1, 2'b00, 18'h00ddd, 1'b0, "R10");
    nop("R10"); nop("R10");
    rd(8'h60, "R10"); rd(8'h61, "R10"); rd(8'h62, "R10"); rd(8'h63, "R10");
    step(1'b0, 1'b0, 3'b010, 1'b1, 8'h61, 2'b11, 18'h0, 1'b1, "R10 interleaved load");
    adv(1'b0, 2'b00, 18'h0, 1'b1, "R5 we ignored");
    adv(1'b0, 2'b00, 18'h0, 1'b1, "R10");
    adv(1'b0, 2'b00, 18'h0, 1'b1, "R10");
    adv(1'b0, 2'b00, 18'h0, 1'b1, "R10 wrap");
    nop("R10"); nop("R10");
  endtask

  task automatic t_cke;
    wr(8'h70, 18'h15555, 2'b00, "R2");
    wr(8'h71, 18'h2aaaa, 2'b00, "R2");
    rd(8'h70, "R2");
    stall("R2"); stall("R2"); stall("R2");
    rd(8'h71, "R2");
    stall("R2");
    nop("R2"); nop("R2");
    rd(8'h70, "R2");
    nop("R2"); nop("R2");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_basic();
    t_bytes();
    t_alt();
    t_sel();
    t_desel();
    t_burst();
    t_cke();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule